// File: doc/BRIEF.md
# Timer Time-Base Counter with Prescaler

This block is the shared time base of a multi-channel timer/PWM unit. It runs at the bus clock and makes a single-cycle count enable from one of three sources. The first source is the bus clock itself. The second is a fixed-frequency enable pulse supplied by the clock system. The third is an external timer clock pin, which can change at any time relative to the bus clock. The external pin is synchronized and edge-detected, so the design stays in one clock domain. An external clock is only guaranteed to be seen correctly up to a quarter of the bus clock rate.

The chosen enable passes through a power-of-two prescaler. Each prescaled enable is driven out as `tick`, which the channels use, and advances a 16-bit counter by one step. The counter runs up to a programmable terminal value. A single mode bit selects the counting mode, and it applies to every channel at once. In edge-aligned mode the counter counts up only. In center-aligned mode it counts up and then back down. A sticky overflow flag marks the end of each period and is cleared by a write-one strobe.

Top module: `tmb_timebase`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `count` is 0, `count_down` is 0, `ovf_flag` is 0 and `tick` is 0.
- R2: `clk_sel` encodes 2'b00 none, 2'b01 bus clock, 2'b10 fixed enable input `fixed_en`, 2'b11 external pin `ext_clk`. With none selected, `tick` stays low and `count` holds its value, whatever `fixed_en` and `ext_clk` do.
- R3: The external pin passes through two synchronizer flops and a rising-edge detector. If `ext_clk` rises before bus edge k, the source enable is high for one cycle between edges k+1 and k+2, and the counter advances at edge k+2.
- R4: For prescaler field `presc_sel` = N (0 to 7), `tick` is high on every 2^N-th source enable, counted from the last divider clear.
- R5: The divider clears in the first cycle in which `clk_sel` differs from its value in the previous cycle, and `tick` is held low in that cycle.
- R6: In edge-aligned mode (`center_mode` = 0) each tick adds one to `count`. A tick when `count` is at or above the terminal value loads 0 instead. `count_down` stays 0 in this mode.
- R7: In edge-aligned mode the overflow flag is set by the tick that wraps the count to 0. The flag is visible in the cycle after that tick.
- R8: In center-aligned mode (`center_mode` = 1) the count goes 0, 1, … M, M-1, … 1, 0, 1, … with one step per tick, where M is the terminal value. `count_down` is 1 while `count` is between M-1 and 0 on the way down.
- R9: In center-aligned mode the overflow flag is set by the tick that turns the count from M to M-1.
- R10: A `modulo` of 0 selects a terminal value of 16'hFFFF, so the counter runs over the full range.
- R11: `ovf_flag` stays set until an `ovf_clr` pulse clears it. If a new overflow happens in the same cycle as the clear, the flag stays set.
- R12: `count` changes only at the end of a cycle in which `tick` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel | input | 2 | Count source select (none, bus, fixed enable, external pin) |
| fixed_en | input | 1 | Fixed-frequency enable pulse, in the bus clock domain |
| ext_clk | input | 1 | External timer clock pin, asynchronous |
| presc_sel | input | 3 | Prescaler exponent N, divide by 2^N |
| modulo | input | 16 | Terminal count value; 0 means full range |
| center_mode | input | 1 | 1 = up/down (center-aligned), 0 = up only (edge-aligned) |
| ovf_clr | input | 1 | Write-one strobe that clears the overflow flag |
| count | output | 16 | Current counter value |
| count_down | output | 1 | Counter is descending (center-aligned only) |
| ovf_flag | output | 1 | Sticky overflow flag |
| tick | output | 1 | Prescaled count enable for the channels |

## Verification
Several rules are checked by assertions on every cycle. The count holds whenever there is no tick. No tick is produced while no source is selected or while the select is changing. The flag only rises after a tick. The count direction turns back up at the bottom of a center-aligned period. Other behaviour can only be shown by the bench's scenarios, run against an independent cycle model. This covers the exact prescaler ratios, the three-cycle latency of the external pin and the sequence of counts and the flag position in both modes. It also covers the full 16-bit wrap when the modulo is 0 and the priority of a set over a clear on the flag.

// File: rtl/tmb_pkg.sv
package tmb_pkg;
   typedef enum logic [1:0] {
      SRC_NONE  = 2'b00,
      SRC_BUS   = 2'b01,
      SRC_FIXED = 2'b10,
      SRC_PIN   = 2'b11
   } tmb_src_e;
endpackage

// File: rtl/tmb_clk_source.sv
module tmb_clk_source
   import tmb_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] clk_sel,
   input  logic       fixed_en,
   input  logic       ext_clk,
   output logic       src_en
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tmb_clk_source: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   edge_q;
   logic                   pin_rise;

   // synchronizer chain, one flop per stage
   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q[0] <= 1'b0;
            else        sync_q[0] <= ext_clk;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q[s] <= 1'b0;
            else        sync_q[s] <= sync_q[s-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) edge_q <= 1'b0;
      else        edge_q <= sync_q[SYNC_STAGES-1];
   end

   assign pin_rise = sync_q[SYNC_STAGES-1] & ~edge_q;

   always_comb begin
      unique case (tmb_src_e'(clk_sel))
         SRC_BUS:   src_en = 1'b1;
         SRC_FIXED: src_en = fixed_en;
         SRC_PIN:   src_en = pin_rise;
         default:   src_en = 1'b0;
      endcase
   end

   // R3
   pin_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pin_rise |=> !pin_rise);

   // R2
   none_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_sel == SRC_NONE) |-> !src_en);
endmodule

// File: rtl/tmb_prescaler.sv
module tmb_prescaler #(
   parameter int PS_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            src_en,
   input  logic [PS_W-1:0] presc_sel,
   input  logic            restart,
   output logic            tick
);
   localparam int DIV_W = (1 << PS_W) - 1;

   if (PS_W < 1 || PS_W > 4) begin : g_bad_ps
      $error("tmb_prescaler: PS_W must be 1..4");
   end

   logic [DIV_W-1:0] div_q;
   logic [DIV_W:0]   pow2;
   logic [DIV_W-1:0] mask;

   assign pow2 = (DIV_W+1)'(1) << presc_sel;
   assign mask = pow2[DIV_W-1:0] - DIV_W'(1);
   assign tick = src_en & ~restart & ((div_q & mask) == mask);

   always_ff @(posedge clk) begin
      if (!rst_n)       div_q <= '0;
      else if (restart) div_q <= '0;
      else if (src_en)  div_q <= div_q + DIV_W'(1);
   end

   // R5
   restart_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |-> !tick);

   // R4
   tick_needs_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> src_en);
endmodule

// File: rtl/tmb_updown_counter.sv
module tmb_updown_counter #(
   parameter int CNT_W      = 16,
   parameter bit ZERO_FULL  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             center_mode,
   input  logic [CNT_W-1:0] modulo,
   input  logic             ovf_clr,
   output logic [CNT_W-1:0] count,
   output logic             count_down,
   output logic             ovf_flag
);
   if (CNT_W < 2) begin : g_bad_w
      $error("tmb_updown_counter: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] term;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             dir_q, dir_d;
   logic             flag_q;
   logic             ovf_ev;
   logic             at_top;

   if (ZERO_FULL) begin : g_zero_full
      assign term = (modulo == '0) ? {CNT_W{1'b1}} : modulo;
   end else begin : g_zero_plain
      assign term = modulo;
   end

   assign at_top = (cnt_q >= term);

   always_comb begin
      cnt_d  = cnt_q;
      dir_d  = dir_q;
      ovf_ev = 1'b0;
      if (!center_mode) begin
         dir_d = 1'b0;
         if (tick) begin
            if (at_top) begin
               cnt_d  = '0;
               ovf_ev = 1'b1;
            end else begin
               cnt_d = cnt_q + CNT_W'(1);
            end
         end
      end else if (tick) begin
         if (!dir_q) begin
            if (at_top) begin
               dir_d  = 1'b1;
               cnt_d  = cnt_q - CNT_W'(1);
               ovf_ev = 1'b1;
            end else begin
               cnt_d = cnt_q + CNT_W'(1);
            end
         end else if (cnt_q == '0) begin
            dir_d = 1'b0;
            cnt_d = CNT_W'(1);
         end else begin
            cnt_d = cnt_q - CNT_W'(1);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         dir_q  <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         dir_q <= dir_d;
         if (ovf_ev)       flag_q <= 1'b1;
         else if (ovf_clr) flag_q <= 1'b0;
      end
   end

   assign count      = cnt_q;
   assign count_down = dir_q & center_mode;
   assign ovf_flag   = flag_q;

   // R12
   hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(count));

   // R11
   flag_from_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> $past(tick));

   // R8
   bottom_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (center_mode && tick && count_down && count == '0) |=> !dir_q);
endmodule

// File: rtl/tmb_timebase.sv
module tmb_timebase
   import tmb_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PS_W        = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       clk_sel,
   input  logic             fixed_en,
   input  logic             ext_clk,
   input  logic [PS_W-1:0]  presc_sel,
   input  logic [CNT_W-1:0] modulo,
   input  logic             center_mode,
   input  logic             ovf_clr,
   output logic [CNT_W-1:0] count,
   output logic             count_down,
   output logic             ovf_flag,
   output logic             tick
);
   logic       src_en;
   logic [1:0] sel_q;
   logic       sel_change;

   always_ff @(posedge clk) begin
      if (!rst_n) sel_q <= SRC_NONE;
      else        sel_q <= clk_sel;
   end
   assign sel_change = (clk_sel != sel_q);

   tmb_clk_source #(.SYNC_STAGES(SYNC_STAGES)) u_src (
      .clk      (clk),
      .rst_n    (rst_n),
      .clk_sel  (clk_sel),
      .fixed_en (fixed_en),
      .ext_clk  (ext_clk),
      .src_en   (src_en)
   );

   tmb_prescaler #(.PS_W(PS_W)) u_presc (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_en    (src_en),
      .presc_sel (presc_sel),
      .restart   (sel_change),
      .tick      (tick)
   );

   tmb_updown_counter #(.CNT_W(CNT_W), .ZERO_FULL(1'b1)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick),
      .center_mode (center_mode),
      .modulo      (modulo),
      .ovf_clr     (ovf_clr),
      .count       (count),
      .count_down  (count_down),
      .ovf_flag    (ovf_flag)
   );

   // R5
   sel_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_sel != $past(clk_sel)) |-> !tick);

   // R6
   edge_up_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !center_mode |-> !count_down);
endmodule

// File: tb/tmb_timebase_tb.sv
module tmb_timebase_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  clk_sel = 2'b00;
   logic        fixed_en = 1'b0;
   logic        ext_clk = 1'b0;
   logic [2:0]  presc_sel = 3'd0;
   logic [15:0] modulo = 16'd0;
   logic        center_mode = 1'b0;
   logic        ovf_clr = 1'b0;
   logic [15:0] count;
   logic        count_down;
   logic        ovf_flag;
   logic        tick;

   int checks = 0;
   int fails = 0;
   int cycles = 0;
   string tag = "R1";

   // reference state
   logic        m_s1, m_s2, m_s3;
   logic [1:0]  m_sel;
   logic [6:0]  m_div;
   logic [15:0] m_cnt;
   logic        m_dir;
   logic        m_flag;

   always #5 clk = ~clk;

   tmb_timebase u_dut (
      .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .fixed_en(fixed_en),
      .ext_clk(ext_clk), .presc_sel(presc_sel), .modulo(modulo),
      .center_mode(center_mode), .ovf_clr(ovf_clr), .count(count),
      .count_down(count_down), .ovf_flag(ovf_flag), .tick(tick)
   );

   function automatic logic exp_tick();
      logic       src;
      logic [6:0] mask;
      case (clk_sel)
         2'b01:   src = 1'b1;
         2'b10:   src = fixed_en;
         2'b11:   src = m_s2 & ~m_s3;
         default: src = 1'b0;
      endcase
      mask = 7'((8'd1 << presc_sel) - 8'd1);
      if (clk_sel != m_sel) return 1'b0;
      return src && ((m_div & mask) == mask);
   endfunction

   always @(posedge clk) begin
      logic        t, src;
      logic [15:0] term;
      logic        ev;
      cycles++;
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_s3 = 0; m_sel = 2'b00; m_div = '0;
         m_cnt = '0; m_dir = 0; m_flag = 0;
      end else begin
         t = exp_tick();
         case (clk_sel)
            2'b01:   src = 1'b1;
            2'b10:   src = fixed_en;
            2'b11:   src = m_s2 & ~m_s3;
            default: src = 1'b0;
         endcase
         if (clk_sel != m_sel) m_div = '0;
         else if (src)         m_div = m_div + 7'd1;
         term = (modulo == 16'd0) ? 16'hFFFF : modulo;
         ev = 1'b0;
         if (!center_mode) begin
            m_dir = 1'b0;
            if (t) begin
               if (m_cnt >= term) begin m_cnt = 0; ev = 1; end
               else m_cnt = m_cnt + 16'd1;
            end
         end else if (t) begin
            if (!m_dir) begin
               if (m_cnt >= term) begin m_dir = 1; m_cnt = m_cnt - 16'd1; ev = 1; end
               else m_cnt = m_cnt + 16'd1;
            end else if (m_cnt == 16'd0) begin
               m_dir = 0; m_cnt = 16'd1;
            end else m_cnt = m_cnt - 16'd1;
         end
         if (ev) m_flag = 1'b1;
         else if (ovf_clr) m_flag = 1'b0;
         m_sel = clk_sel;
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_clk;
      end
   end

   task automatic check1(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare();
      check1("count", 32'(count), 32'(m_cnt));
      check1("count_down", 32'(count_down), 32'(m_dir & center_mode));
      check1("ovf_flag", 32'(ovf_flag), 32'(m_flag));
      check1("tick", 32'(tick), 32'(exp_tick()));
   endtask

   // one cycle: compare after the edge, then apply new inputs
   task automatic step();
      @(negedge clk);
      compare();
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   initial begin
      int seed;
      seed = 1234;
      void'($urandom(seed));
      // R1 reset state
      clk_sel = 2'b01;
      repeat (3) @(negedge clk);
      tag = "R1";
      check1("count", 32'(count), 0);
      check1("ovf_flag", 32'(ovf_flag), 0);
      check1("count_down", 32'(count_down), 0);
      rst_n = 1'b1;
      clk_sel = 2'b00;
      step();
      check1("tick", 32'(tick), 0);

      // R2 none selected: inputs toggle, nothing moves
      tag = "R2";
      for (int i = 0; i < 40; i++) begin
         step(); fixed_en = i[0]; ext_clk = i[2];
      end

      // R6 edge-aligned, bus clock, divide by 1, modulo 5
      tag = "R6"; modulo = 16'd5; clk_sel = 2'b01; fixed_en = 0; ext_clk = 0;
      run(5);
      tag = "R7"; run(10);
      // R11 clear alone, then clear coinciding with overflow
      tag = "R11"; ovf_clr = 1; step(); ovf_clr = 0; run(3);
      while (count != 16'd5) step();
      ovf_clr = 1; step(); ovf_clr = 0;
      check1("flag_set_wins", 32'(ovf_flag), 1);
      run(4);

      // R4 fixed enable source with every prescaler setting
      tag = "R4"; modulo = 16'd9;
      for (int n = 0; n < 8; n++) begin
         presc_sel = 3'(n); clk_sel = 2'b10;
         for (int i = 0; i < 300; i++) begin step(); fixed_en = (i % 3) == 0; end
      end
      fixed_en = 0;

      // R3 external pin, slow toggles
      tag = "R3"; presc_sel = 0; clk_sel = 2'b11;
      for (int i = 0; i < 200; i++) begin step(); ext_clk = (i % 6) < 3; end

      // R5 select change mid-division
      tag = "R5"; presc_sel = 3'd2;
      for (int i = 0; i < 60; i++) begin
         step();
         if (i % 7 == 0) clk_sel = (clk_sel == 2'b01) ? 2'b10 : 2'b01;
         fixed_en = i[0];
      end

      // R8 center-aligned up/down, modulo 4
      tag = "R8"; clk_sel = 2'b01; presc_sel = 0; modulo = 16'd4; center_mode = 1;
      run(20);
      tag = "R9"; ovf_clr = 1; step(); ovf_clr = 0; run(20);

      // R10 modulo 0, full range wrap
      tag = "R10"; center_mode = 0; modulo = 16'd0; ovf_clr = 1; step(); ovf_clr = 0;
      while (count != 16'hFFFF) step();
      check1("pre_wrap_flag", 32'(ovf_flag), 0);
      run(3);
      check1("post_wrap_flag", 32'(ovf_flag), 1);

      // R12 constrained random mix
      tag = "R12";
      for (int seg = 0; seg < 120; seg++) begin
         clk_sel = 2'($urandom);
         presc_sel = 3'($urandom_range(0, 3));
         modulo = 16'($urandom_range(0, 12));
         if (modulo == 0 && ($urandom % 4) != 0) modulo = 16'd3;
         center_mode = 1'($urandom);
         for (int i = 0; i < 250; i++) begin
            step();
            fixed_en = ($urandom % 3) == 0;
            if (($urandom % 5) == 0) ext_clk = ~ext_clk;
            ovf_clr = ($urandom % 11) == 0;
         end
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      wait (cycles > 190000);
      fails++;
      $display("FAIL watchdog actual=%0d expected<190000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule